// File: doc/BRIEF.md
# Cache-Line Overlay Translation Unit

This unit sits next to a page-granular translation cache. Each cached page mapping carries a per-line presence vector that shows which 64-byte lines of the 4 KiB page have moved into a small overlay area set aside for that page. A request names a virtual page, a line index and whether it is a write. The unit resolves the page and reads the line's presence bit in the same lookup. It returns one physical line address: the line's place in the original page when the bit is clear, or its overlay slot when the bit is set.

When a write hits a copy-on-write page and the line is not yet in the overlay, the unit takes the next free slot of that page and marks the line present. It also pulses a copy request that tells a data mover which original line to copy into which overlay slot. No other line of the page is duplicated. When every slot of the page is taken, the unit reports a fault instead and leaves the page's state as it was. Entries are loaded through a refill port. Walking page tables, choosing where overlay areas live and moving the data are done elsewhere.

Top module: `line_overlay_xlate`

## Requirements
- R1: After reset no response and no copy request is raised, and every entry is empty, so a request before any refill returns rsp_hit=0.
- R2: A refill of entry slot fill_idx installs the virtual page, physical page, copy-on-write flag and overlay base line address. It clears that entry's presence vector and slot counter.
- R3: Every accepted request produces rsp_valid in the next cycle. A request whose page matches no valid entry returns rsp_hit=0, rsp_ovl=0, rsp_fault=0, rsp_paddr=0 and no copy request.
- R4: An access to a line whose presence bit is clear returns the original line address {ppn, line} with rsp_ovl=0. The line index is address bits [11:6] of a 4 KiB page with 64-byte lines.
- R5: A write to a copy-on-write page whose line bit is clear and whose slot count is below SLOTS takes slot n, where n is the page's current count. It sets the bit, increments the count and returns overlay_base+n with rsp_ovl=1. In the same cycle it raises copy_valid for exactly one cycle, with copy_src={ppn, line} and copy_dst=overlay_base+n.
- R6: Any access to a line whose presence bit is set returns overlay_base plus the slot that line was given, with no new allocation and no copy request.
- R7: Reads never change the presence vector or the slot count. A line that was read first is still given the next free slot on its first write.
- R8: A write to a page that is not copy-on-write goes to the original line address and allocates nothing.
- R9: A write that would need a slot when all SLOTS slots of the page are used returns rsp_fault=1, the original line address and no copy request. It leaves the line's bit clear.
- R10: Slot counters are kept per page, so allocations on one page do not use up the slots of another page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Load one entry |
| fill_idx | input | IDX_W | Entry slot to load |
| fill_vpn | input | VPN_W | Virtual page number |
| fill_ppn | input | PPN_W | Original physical page number |
| fill_cow | input | 1 | Page is copy-on-write |
| fill_obase | input | PLA_W | Overlay base physical line address |
| req_valid | input | 1 | Access request |
| req_vpn | input | VPN_W | Requested virtual page |
| req_line | input | LIDX_W | Line index inside the page |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | Page found |
| rsp_ovl | output | 1 | Address points into the overlay |
| rsp_fault | output | 1 | Overlay full on a write needing a slot |
| rsp_paddr | output | PLA_W | Selected physical line address |
| copy_valid | output | 1 | One-cycle line copy request |
| copy_src | output | PLA_W | Line to copy from |
| copy_dst | output | PLA_W | Overlay slot to copy into |

## Verification
The bench fills a page's overlay exactly to capacity and then writes once more. A design with an off-by-one in the full test would either allocate a fifth slot past the area or fault one write early. It rewrites and rereads lines that are already overlaid, which catches a design that allocates again or forgets which slot a line was given. Reads placed before first writes show whether reads leak into the presence vector. Interleaved writes to two copy-on-write pages expose a single shared counter. A refill of a populated entry must bring back original addresses and slot zero.

// File: rtl/line_overlay_pkg.sv
package line_overlay_pkg;

   // outcome of one lookup
   typedef enum logic [2:0] {
      RT_MISS  = 3'd0,
      RT_BASE  = 3'd1,
      RT_OVL   = 3'd2,
      RT_ALLOC = 3'd3,
      RT_FULL  = 3'd4
   } route_e;

   function automatic int unsigned width_of(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/olt_match.sv
module olt_match #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned IDX_W   = 2
) (
   input  logic [ENTRIES-1:0]            ent_valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
   input  logic [VPN_W-1:0]              key,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx
);

   logic [ENTRIES-1:0] eq;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign eq[e] = ent_valid[e] && (ent_vpn[e] == key);
   end

   // lowest matching slot wins if software ever installs duplicates
   always_comb begin
      hit     = |eq;
      hit_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (eq[e]) hit_idx = IDX_W'(e);
      end
   end

endmodule

// File: rtl/olt_route.sv
module olt_route
   import line_overlay_pkg::*;
#(
   parameter int unsigned LIDX_W = 6,
   parameter int unsigned PPN_W  = 16,
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned SLOT_W = 2,
   parameter int unsigned CNT_W  = 3,
   parameter int unsigned PLA_W  = 22
) (
   input  logic              hit,
   input  logic              is_write,
   input  logic              cow,
   input  logic              line_present,
   input  logic [CNT_W-1:0]  used,
   input  logic [SLOT_W-1:0] line_slot,
   input  logic [PPN_W-1:0]  ppn,
   input  logic [PLA_W-1:0]  obase,
   input  logic [LIDX_W-1:0] line,
   output route_e            kind,
   output logic [PLA_W-1:0]  paddr,
   output logic [PLA_W-1:0]  src_addr,
   output logic [PLA_W-1:0]  dst_addr
);

   logic [PLA_W-1:0] orig_addr;
   logic [PLA_W-1:0] held_addr;
   logic [PLA_W-1:0] next_addr;
   logic             full;

   assign orig_addr = {ppn, line};
   assign held_addr = obase + PLA_W'(line_slot);
   assign next_addr = obase + PLA_W'(used);
   assign full      = (used >= CNT_W'(SLOTS));

   always_comb begin
      if (!hit)                  kind = RT_MISS;
      else if (line_present)     kind = RT_OVL;
      else if (!is_write || !cow) kind = RT_BASE;
      else if (full)             kind = RT_FULL;
      else                       kind = RT_ALLOC;
   end

   always_comb begin
      unique case (kind)
         RT_MISS:  paddr = '0;
         RT_OVL:   paddr = held_addr;
         RT_ALLOC: paddr = next_addr;
         default:  paddr = orig_addr;
      endcase
   end

   assign src_addr = orig_addr;
   assign dst_addr = next_addr;

endmodule

// File: rtl/line_overlay_xlate.sv
module line_overlay_xlate
   import line_overlay_pkg::*;
#(
   parameter int unsigned ENTRIES    = 4,
   parameter int unsigned VPN_W      = 20,
   parameter int unsigned PPN_W      = 16,
   parameter int unsigned PAGE_BYTES = 4096,
   parameter int unsigned LINE_BYTES = 64,
   parameter int unsigned SLOTS      = 4,
   localparam int unsigned LINES     = PAGE_BYTES / LINE_BYTES,
   localparam int unsigned LIDX_W    = width_of(LINES),
   localparam int unsigned IDX_W     = width_of(ENTRIES),
   localparam int unsigned PLA_W     = PPN_W + LIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic              fill_cow,
   input  logic [PLA_W-1:0]  fill_obase,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   input  logic [LIDX_W-1:0] req_line,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_ovl,
   output logic              rsp_fault,
   output logic [PLA_W-1:0]  rsp_paddr,
   output logic              copy_valid,
   output logic [PLA_W-1:0]  copy_src,
   output logic [PLA_W-1:0]  copy_dst
);

   localparam int unsigned SLOT_W = width_of(SLOTS);
   localparam int unsigned CNT_W  = $clog2(SLOTS + 1);

   // elaboration-time parameter checks
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES >= PAGE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two below PAGE_BYTES");
   end
   if (SLOTS < 1 || SLOTS > LINES) begin : g_bad_slots
      $error("SLOTS must lie in 1..LINES");
   end
   if (ENTRIES < 1) begin : g_bad_entries
      $error("ENTRIES must be at least one");
   end

   // per-entry views, each driven from its own generate branch
   logic [ENTRIES-1:0]             e_valid;
   logic [ENTRIES-1:0]             e_cow;
   logic [ENTRIES-1:0]             e_present;
   logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
   logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
   logic [ENTRIES-1:0][PLA_W-1:0]  e_obase;
   logic [ENTRIES-1:0][CNT_W-1:0]  e_used;
   logic [ENTRIES-1:0][SLOT_W-1:0] e_slot;

   logic              hit;
   logic [IDX_W-1:0]  hit_idx;
   route_e            kind;
   logic [PLA_W-1:0]  sel_paddr;
   logic [PLA_W-1:0]  sel_src;
   logic [PLA_W-1:0]  sel_dst;
   logic              do_alloc;

   olt_match #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .IDX_W   (IDX_W)
   ) u_match (
      .ent_valid (e_valid),
      .ent_vpn   (e_vpn),
      .key       (req_vpn),
      .hit       (hit),
      .hit_idx   (hit_idx)
   );

   olt_route #(
      .LIDX_W (LIDX_W),
      .PPN_W  (PPN_W),
      .SLOTS  (SLOTS),
      .SLOT_W (SLOT_W),
      .CNT_W  (CNT_W),
      .PLA_W  (PLA_W)
   ) u_route (
      .hit          (hit),
      .is_write     (req_write),
      .cow          (e_cow[hit_idx]),
      .line_present (e_present[hit_idx]),
      .used         (e_used[hit_idx]),
      .line_slot    (e_slot[hit_idx]),
      .ppn          (e_ppn[hit_idx]),
      .obase        (e_obase[hit_idx]),
      .line         (req_line),
      .kind         (kind),
      .paddr        (sel_paddr),
      .src_addr     (sel_src),
      .dst_addr     (sel_dst)
   );

   assign do_alloc = req_valid && (kind == RT_ALLOC);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic              valid_q;
      logic              cow_q;
      logic [VPN_W-1:0]  vpn_q;
      logic [PPN_W-1:0]  ppn_q;
      logic [PLA_W-1:0]  obase_q;
      logic [LINES-1:0]  present_q;
      logic [CNT_W-1:0]  used_q;
      logic [SLOT_W-1:0] slot_q [LINES];
      logic              load;
      logic              grab;

      assign load = fill_valid && (fill_idx == IDX_W'(e));
      assign grab = do_alloc && (hit_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q   <= 1'b0;
            cow_q     <= 1'b0;
            vpn_q     <= '0;
            ppn_q     <= '0;
            obase_q   <= '0;
            present_q <= '0;
            used_q    <= '0;
         end else if (load) begin
            valid_q   <= 1'b1;
            cow_q     <= fill_cow;
            vpn_q     <= fill_vpn;
            ppn_q     <= fill_ppn;
            obase_q   <= fill_obase;
            present_q <= '0;
            used_q    <= '0;
         end else if (grab) begin
            present_q[req_line] <= 1'b1;
            used_q              <= used_q + 1'b1;
         end
      end

      // slot numbers are only read where the presence bit is set
      always_ff @(posedge clk) begin
         if (grab && !load) slot_q[req_line] <= SLOT_W'(used_q);
      end

      assign e_valid[e]   = valid_q;
      assign e_cow[e]     = cow_q;
      assign e_vpn[e]     = vpn_q;
      assign e_ppn[e]     = ppn_q;
      assign e_obase[e]   = obase_q;
      assign e_used[e]    = used_q;
      assign e_present[e] = present_q[req_line];
      assign e_slot[e]    = slot_q[req_line];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_ovl    <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_paddr  <= '0;
         copy_valid <= 1'b0;
         copy_src   <= '0;
         copy_dst   <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_hit    <= req_valid && hit;
         rsp_ovl    <= req_valid && (kind == RT_OVL || kind == RT_ALLOC);
         rsp_fault  <= req_valid && (kind == RT_FULL);
         rsp_paddr  <= req_valid ? sel_paddr : '0;
         copy_valid <= do_alloc;
         if (do_alloc) begin
            copy_src <= sel_src;
            copy_dst <= sel_dst;
         end
      end
   end

endmodule

// File: rtl/line_overlay_chk.sv
module line_overlay_chk #(
   parameter int unsigned PLA_W = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic             rsp_ovl,
   input logic             rsp_fault,
   input logic [PLA_W-1:0] rsp_paddr,
   input logic             copy_valid,
   input logic [PLA_W-1:0] copy_dst
);

   p_rsp_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !copy_valid);

   p_miss_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (!rsp_ovl && !rsp_fault && !copy_valid));

   p_copy_matches_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      copy_valid |-> (rsp_hit && rsp_ovl && !rsp_fault && rsp_paddr == copy_dst));

   p_copy_only_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write |=> !copy_valid);

   p_fault_no_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (!copy_valid && !rsp_ovl && rsp_hit));

endmodule

bind line_overlay_xlate line_overlay_chk #(.PLA_W(PLA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_ovl    (rsp_ovl),
   .rsp_fault  (rsp_fault),
   .rsp_paddr  (rsp_paddr),
   .copy_valid (copy_valid),
   .copy_dst   (copy_dst)
);

// File: tb/line_overlay_xlate_tb.sv
module line_overlay_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_valid = 1'b0;
   logic [1:0]  fill_idx = '0;
   logic [19:0] fill_vpn = '0;
   logic [15:0] fill_ppn = '0;
   logic        fill_cow = 1'b0;
   logic [21:0] fill_obase = '0;
   logic        req_valid = 1'b0;
   logic [19:0] req_vpn = '0;
   logic [5:0]  req_line = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_ovl, rsp_fault, copy_valid;
   logic [21:0] rsp_paddr, copy_src, copy_dst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   line_overlay_xlate u_dut (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
      .fill_ppn(fill_ppn), .fill_cow(fill_cow), .fill_obase(fill_obase),
      .req_valid(req_valid), .req_vpn(req_vpn), .req_line(req_line),
      .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ovl(rsp_ovl),
      .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
      .copy_valid(copy_valid), .copy_src(copy_src), .copy_dst(copy_dst)
   );

   // pages: A vpn 0x10 -> ppn 0x100 cow, B vpn 0x20 -> ppn 0x200 plain,
   //        C vpn 0x30 -> ppn 0x300 cow
   localparam logic [19:0] VA = 20'h10, VB = 20'h20, VC = 20'h30;

   typedef struct packed {
      logic        we;
      logic [19:0] vpn;
      logic [5:0]  line;
      logic        hit;
      logic        ovl;
      logic        flt;
      logic        cp;
      logic [21:0] pa;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{1'b0, VA, 6'd5,  1'b1, 1'b0, 1'b0, 1'b0, 22'h04005, 8'd4},  // R4 read, clear bit
      '{1'b1, VA, 6'd5,  1'b1, 1'b1, 1'b0, 1'b1, 22'h3F000, 8'd5},  // R5 slot 0
      '{1'b0, VA, 6'd5,  1'b1, 1'b1, 1'b0, 1'b0, 22'h3F000, 8'd6},  // R6 reread
      '{1'b1, VA, 6'd5,  1'b1, 1'b1, 1'b0, 1'b0, 22'h3F000, 8'd6},  // R6 rewrite
      '{1'b1, VA, 6'd9,  1'b1, 1'b1, 1'b0, 1'b1, 22'h3F001, 8'd5},  // R5 slot 1
      '{1'b1, VC, 6'd9,  1'b1, 1'b1, 1'b0, 1'b1, 22'h3F200, 8'd10}, // R10 own counter
      '{1'b0, VA, 6'd9,  1'b1, 1'b1, 1'b0, 1'b0, 22'h3F001, 8'd6},  // R6
      '{1'b1, VB, 6'd3,  1'b1, 1'b0, 1'b0, 1'b0, 22'h08003, 8'd8},  // R8 plain write
      '{1'b0, VB, 6'd3,  1'b1, 1'b0, 1'b0, 1'b0, 22'h08003, 8'd8},  // R8
      '{1'b1, VA, 6'd63, 1'b1, 1'b1, 1'b0, 1'b1, 22'h3F002, 8'd5},  // R5 slot 2
      '{1'b1, VA, 6'd0,  1'b1, 1'b1, 1'b0, 1'b1, 22'h3F003, 8'd5},  // R5 last slot
      '{1'b1, VA, 6'd1,  1'b1, 1'b0, 1'b1, 1'b0, 22'h04001, 8'd9},  // R9 full
      '{1'b0, VA, 6'd1,  1'b1, 1'b0, 1'b0, 1'b0, 22'h04001, 8'd9},  // R9 bit unchanged
      '{1'b1, VA, 6'd1,  1'b1, 1'b0, 1'b1, 1'b0, 22'h04001, 8'd9},  // R9 again
      '{1'b0, VA, 6'd0,  1'b1, 1'b1, 1'b0, 1'b0, 22'h3F003, 8'd6},  // R6
      '{1'b0, 20'h99, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 22'h0,   8'd3},  // R3 miss
      '{1'b0, VC, 6'd9,  1'b1, 1'b1, 1'b0, 1'b0, 22'h3F200, 8'd6},  // R6
      '{1'b0, VC, 6'd20, 1'b1, 1'b0, 1'b0, 1'b0, 22'h0C014, 8'd7},  // R7 read first
      '{1'b1, VC, 6'd20, 1'b1, 1'b1, 1'b0, 1'b1, 22'h3F201, 8'd7}   // R7 next slot
   };

   function automatic logic [21:0] orig(input logic [19:0] v, input logic [5:0] l);
      logic [15:0] p;
      p = (v == VA) ? 16'h100 : (v == VB) ? 16'h200 : 16'h300;
      return {p, l};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic fill(input logic [1:0] idx, input logic [19:0] v, input logic [15:0] p,
                       input logic cow, input logic [21:0] ob);
      @(negedge clk);
      fill_valid = 1'b1; fill_idx = idx; fill_vpn = v; fill_ppn = p;
      fill_cow = cow; fill_obase = ob;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   // response is registered: sampled on the falling edge after the capturing edge
   task automatic access(input logic we, input logic [19:0] v, input logic [5:0] l);
      @(negedge clk);
      req_valid = 1'b1; req_write = we; req_vpn = v; req_line = l;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(input string tag, input logic hit, input logic ovl,
                             input logic flt, input logic cp, input logic [21:0] pa,
                             input logic [21:0] src);
      check({tag, " valid"}, 32'(rsp_valid), 32'd1);
      check({tag, " hit"},   32'(rsp_hit),   32'(hit));
      check({tag, " ovl"},   32'(rsp_ovl),   32'(ovl));
      check({tag, " fault"}, 32'(rsp_fault), 32'(flt));
      check({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
      check({tag, " copy"},  32'(copy_valid), 32'(cp));
      if (cp) begin
         check({tag, " copy_src"}, 32'(copy_src), 32'(src));
         check({tag, " copy_dst"}, 32'(copy_dst), 32'(pa));
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle while and just after reset
      check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      check("R1 copy_valid in reset", 32'(copy_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      access(1'b1, VA, 6'd5);
      expect_rsp("R1 empty table miss", 1'b0, 1'b0, 1'b0, 1'b0, 22'h0, 22'h0);

      fill(2'd0, VA, 16'h100, 1'b1, 22'h3F000);
      fill(2'd1, VB, 16'h200, 1'b0, 22'h3F100);
      fill(2'd2, VC, 16'h300, 1'b1, 22'h3F200);

      for (int i = 0; i < NV; i++) begin
         access(TBL[i].we, TBL[i].vpn, TBL[i].line);
         expect_rsp($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].hit, TBL[i].ovl,
                    TBL[i].flt, TBL[i].cp, TBL[i].pa, orig(TBL[i].vpn, TBL[i].line));
      end

      // idle cycle: no response, no copy (R3)
      @(negedge clk);
      check("R3 idle rsp_valid", 32'(rsp_valid), 32'd0);
      check("R3 idle copy_valid", 32'(copy_valid), 32'd0);

      // R2: reloading page A clears its vector and counter
      fill(2'd0, VA, 16'h100, 1'b1, 22'h3F000);
      access(1'b0, VA, 6'd5);
      expect_rsp("R2 refill clears bit", 1'b1, 1'b0, 1'b0, 1'b0, 22'h04005, 22'h0);
      access(1'b1, VA, 6'd7);
      expect_rsp("R2 refill restarts slot", 1'b1, 1'b1, 1'b0, 1'b1, 22'h3F000, 22'h04007);

      // R2: reload entry 1 with a new page; old page now misses
      fill(2'd1, 20'h44, 16'h0AB, 1'b0, 22'h3F300);
      access(1'b0, VB, 6'd3);
      expect_rsp("R2 old page gone", 1'b0, 1'b0, 1'b0, 1'b0, 22'h0, 22'h0);
      access(1'b0, 20'h44, 6'd3);
      expect_rsp("R2 new page", 1'b1, 1'b0, 1'b0, 1'b0, {16'h0AB, 6'd3}, 22'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule